// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects single-cycle event pulses from up to sixteen peripheral sources into a pending register, and qualifies them with an enable register. From the two it derives one level-sensitive request line toward the processor. The request stays high while at least one pending source is also enabled. Software reads both registers over a simple register bus. It acknowledges events by storing a value that is ANDed into the pending register, so a zero clears a bit and a one leaves it alone.

One source input is kept apart as a dedicated port for the DMA engine. It lands on bit 3 of the pending register. When software stores an enable value that covers a source already pending, the block raises a one-cycle re-evaluation pulse. The processor side can then take the interrupt at once, without waiting for a new event.

Only the low 16 bits of a store are wired into the block. A 16-bit store and a 32-bit store to the same offset therefore behave the same. Reads return the 16-bit registers zero-extended to 32 bits.

Top module: `irq_status_ctl`

## Requirements
- R1: While reset is low, and in the first cycle after it, the pending and enable registers read 0, and `cpuIrq` and `recheckPulse` are 0.
- R2: A 1 on `srcPulse[i]` sets pending bit i at the next clock edge. The bit then stays set until software acknowledges it.
- R3: A store to offset 0x070 replaces the pending register with (pending AND `busWdata`). Written zeros clear bits and written ones keep them.
- R4: When a source pulse and an acknowledge that clears the same bit arrive in one cycle, the bit ends up set.
- R5: A store to offset 0x074 loads `busWdata` into the enable register unchanged.
- R6: `cpuIrq` is 1 exactly when (pending AND enable) is nonzero. It follows any change of either register in the cycle after the edge that changed it, whether or not a register store caused the change.
- R7: `recheckPulse` is 1 for the single cycle after an enable store whose value overlaps the pending bits held before that store. It is 0 in every other cycle.
- R8: A store to any offset other than 0x070 or 0x074 changes neither register.
- R9: A 1 on `dmaPulse` sets pending bit 3, in the same way as a source pulse.
- R10: `busRdata` returns the pending register zero-extended at offset 0x070, the enable register zero-extended at offset 0x074, and 0 at any other offset. The value is combinational on `busAddr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Register byte offset |
| busWe | input | 1 | Store strobe |
| busWdata | input | 16 | Store data (low half of the processor store) |
| busRdata | output | 32 | Read data for `busAddr` |
| srcPulse | input | 16 | Peripheral event pulses, one per pending bit |
| dmaPulse | input | 1 | DMA engine event pulse, routed to bit 3 |
| cpuIrq | output | 1 | Level interrupt request |
| recheckPulse | output | 1 | One-cycle re-evaluation pulse after an enable store |

## Verification
On every cycle, the assertions check the register updates against the previous cycle. They cover the AND acknowledge with the set-wins merge, the direct enable load, bits staying set once a source has fired, pending bits holding when nothing touches them, and the re-evaluation pulse appearing only after an enable store. Some properties can only be shown by the bench's scenarios, because they concern values seen at the ports. These are the request level observed through the bus, stores to unused offsets leaving both registers unchanged, the DMA input landing on bit 3, and the read multiplexer returning zero at unused offsets. The bench compares every cycle of a long random run against its own register model.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

  // Strobes from the bus decoder into the register datapath
  typedef struct packed {
    logic statusWr;
    logic maskWr;
    logic statusRd;
    logic maskRd;
  } regStrobe_t;

endpackage

// File: rtl/irq_status_decode.sv
module irq_status_decode
  import irq_status_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int STATUS_OFS = 'h070,
  parameter int MASK_OFS   = 'h074
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output regStrobe_t        strb
);

  localparam logic [ADDR_W-1:0] StatusAddr = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] MaskAddr   = ADDR_W'(MASK_OFS);

  logic hitStatus;
  logic hitMask;

  always_comb begin
    hitStatus     = (busAddr == StatusAddr);
    hitMask       = (busAddr == MaskAddr);
    strb.statusWr = busWe & hitStatus;
    strb.maskWr   = busWe & hitMask;
    strb.statusRd = hitStatus;
    strb.maskRd   = hitMask;
  end

endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
  import irq_status_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int RDATA_W = 32,
  parameter int DMA_BIT = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strb,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [NUM_SRC-1:0] srcPulse,
  input  logic               dmaPulse,
  output logic [RDATA_W-1:0] rdData,
  output logic               cpuIrq,
  output logic               recheck
);

  localparam int PadW = RDATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] setVec;
  logic               recheckQ;

  // One pending cell per source; a set always beats an acknowledge
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
    if (i == DMA_BIT) begin : g_dma
      assign setVec[i] = srcPulse[i] | dmaPulse;
    end else begin : g_plain
      assign setVec[i] = srcPulse[i];
    end

    always_ff @(posedge clk) begin
      if (!rstN)
        status[i] <= 1'b0;
      else if (setVec[i])
        status[i] <= 1'b1;
      else if (strb.statusWr)
        status[i] <= status[i] & wrData[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mask     <= '0;
      recheckQ <= 1'b0;
    end else begin
      if (strb.maskWr) mask <= wrData;
      recheckQ <= strb.maskWr & (|(status & wrData));
    end
  end

  assign cpuIrq  = |(status & mask);
  assign recheck = recheckQ;

  always_comb begin
    rdData = '0;
    if (strb.statusRd)    rdData = {{PadW{1'b0}}, status};
    else if (strb.maskRd) rdData = {{PadW{1'b0}}, mask};
  end

  // R3 and R4: acknowledge ANDs in, same-cycle sets are merged on top
  assert_ack_merge_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.statusWr |=> status == (($past(status) & $past(wrData)) | $past(setVec)));

  // R5: enable register takes the stored value unchanged
  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskWr |=> mask == $past(wrData));

  // R2: a fired source is pending in the next cycle
  assert_src_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|setVec) |=> (($past(setVec) & ~status) == '0));

  // R2: pending bits hold when no store and no event touches them
  assert_status_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.statusWr && setVec == '0) |=> $stable(status));

  // R7: re-evaluation pulse only follows an enable store
  assert_recheck_src_R7: assert property (@(posedge clk) disable iff (!rstN)
    recheckQ |-> $past(strb.maskWr));

endmodule

// File: rtl/irq_status_ctl.sv
module irq_status_ctl
  import irq_status_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_SRC    = 16,
  parameter int RDATA_W    = 32,
  parameter int DMA_BIT    = 3,
  parameter int STATUS_OFS = 'h070,
  parameter int MASK_OFS   = 'h074
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [NUM_SRC-1:0] busWdata,
  output logic [RDATA_W-1:0] busRdata,
  input  logic [NUM_SRC-1:0] srcPulse,
  input  logic               dmaPulse,
  output logic               cpuIrq,
  output logic               recheckPulse
);

  regStrobe_t strb;

  irq_status_decode #(
    .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS), .MASK_OFS(MASK_OFS)
  ) u_decode (
    .busAddr(busAddr), .busWe(busWe), .strb(strb)
  );

  irq_status_regs #(
    .NUM_SRC(NUM_SRC), .RDATA_W(RDATA_W), .DMA_BIT(DMA_BIT)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWdata),
    .srcPulse(srcPulse), .dmaPulse(dmaPulse), .rdData(busRdata),
    .cpuIrq(cpuIrq), .recheck(recheckPulse)
  );

endmodule

// File: tb/irq_status_ctl_tb.sv
module irq_status_ctl_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [11:0] busAddr;
  logic        busWe;
  logic [15:0] busWdata;
  logic [31:0] busRdata;
  logic [15:0] srcPulse;
  logic        dmaPulse;
  logic        cpuIrq;
  logic        recheckPulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] mSt = '0;
  logic [15:0] mMk = '0;

  always #10 clk = ~clk;

  irq_status_ctl u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .srcPulse(srcPulse),
    .dmaPulse(dmaPulse), .cpuIrq(cpuIrq), .recheckPulse(recheckPulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [11:0] a, input logic [15:0] st,
                                          input logic [15:0] mk);
    if (a == 12'h070) return {16'h0, st};
    if (a == 12'h074) return {16'h0, mk};
    return 32'h0;
  endfunction

  // One bus cycle: drive at the falling edge, check after the rising edge
  task automatic step(input logic [11:0] a, input logic we, input logic [15:0] wd,
                      input logic [15:0] src, input logic dma);
    logic [15:0] setV, nSt, nMk;
    logic        expRe;
    @(negedge clk);
    busAddr = a; busWe = we; busWdata = wd; srcPulse = src; dmaPulse = dma;
    setV  = src | (16'(dma) << 3);
    nSt   = ((we && a == 12'h070) ? (mSt & wd) : mSt) | setV;
    nMk   = (we && a == 12'h074) ? wd : mMk;
    expRe = we && a == 12'h074 && ((mSt & wd) != 16'h0);
    @(posedge clk);
    #5;
    mSt = nSt; mMk = nMk;
    chk("R6 cpuIrq level", 32'(cpuIrq), 32'(((mSt & mMk) != 16'h0)));
    chk("R7 recheck pulse", 32'(recheckPulse), 32'(expRe));
    chk("R10 read mux", busRdata, expRead(a, mSt, mMk));
  endtask

  initial begin
    rstN = 1'b0; busAddr = 12'h070; busWe = 1'b0; busWdata = '0;
    srcPulse = '0; dmaPulse = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    chk("R1 irq in reset", 32'(cpuIrq), 32'h0);
    chk("R1 recheck in reset", 32'(recheckPulse), 32'h0);
    chk("R1 pending in reset", busRdata, 32'h0);
    busAddr = 12'h074; #1;
    chk("R1 enable in reset", busRdata, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R2: source 5 fires, stays pending over idle cycles
    step(12'h070, 1'b0, 16'h0, 16'h0020, 1'b0);
    chk("R2 bit5 set", busRdata, 32'h0000_0020);
    step(12'h070, 1'b0, 16'h0, 16'h0, 1'b0);
    step(12'h070, 1'b0, 16'h0, 16'h0, 1'b0);
    chk("R2 bit5 held", busRdata, 32'h0000_0020);

    // R9: DMA input lands on bit 3
    step(12'h070, 1'b0, 16'h0, 16'h0, 1'b1);
    chk("R9 dma on bit3", busRdata, 32'h0000_0028);

    // R3: clear bit 5 only
    step(12'h070, 1'b1, 16'hFFDF, 16'h0, 1'b0);
    chk("R3 ack clears bit5", busRdata, 32'h0000_0008);

    // R5, R7, R6: enable bit 3 while it is pending
    step(12'h074, 1'b1, 16'h0008, 16'h0, 1'b0);
    chk("R5 enable loaded", busRdata, 32'h0000_0008);
    chk("R7 pulse on overlap", 32'(recheckPulse), 32'h1);
    chk("R6 irq raised", 32'(cpuIrq), 32'h1);
    step(12'h074, 1'b0, 16'h0, 16'h0, 1'b0);
    chk("R7 single cycle", 32'(recheckPulse), 32'h0);

    // R4: acknowledge all while bit 3 fires again
    step(12'h070, 1'b1, 16'h0000, 16'h0008, 1'b0);
    chk("R4 set wins", busRdata, 32'h0000_0008);

    // R6: clear, then a bare event raises the line with no store
    step(12'h070, 1'b1, 16'h0000, 16'h0, 1'b0);
    chk("R6 irq low after ack", 32'(cpuIrq), 32'h0);
    step(12'h070, 1'b0, 16'h0, 16'h0008, 1'b0);
    chk("R6 irq from event", 32'(cpuIrq), 32'h1);

    // R8: stores to other offsets change nothing
    step(12'h072, 1'b1, 16'h0000, 16'h0, 1'b0);
    step(12'h000, 1'b1, 16'hFFFF, 16'h0, 1'b0);
    step(12'h070, 1'b0, 16'h0, 16'h0, 1'b0);
    chk("R8 pending untouched", busRdata, 32'h0000_0008);
    step(12'h074, 1'b0, 16'h0, 16'h0, 1'b0);
    chk("R8 enable untouched", busRdata, 32'h0000_0008);
    step(12'h072, 1'b0, 16'h0, 16'h0, 1'b0);
    chk("R10 unused offset reads 0", busRdata, 32'h0);

    // R7: enable store with no overlap gives no pulse
    step(12'h074, 1'b1, 16'h0010, 16'h0, 1'b0);
    chk("R7 no pulse without overlap", 32'(recheckPulse), 32'h0);

    // Random traffic against the model
    begin
      int unsigned seed = $urandom(32'h5EED_1234);
      seed = seed;
      for (int n = 0; n < 4000; n++) begin
        int unsigned r = $urandom();
        logic [11:0] a;
        case (r[1:0])
          2'd0: a = 12'h070;
          2'd1: a = 12'h074;
          2'd2: a = 12'h072;
          default: a = 12'h0F0;
        endcase
        step(a, r[2], 16'($urandom()),
             (r[5:3] == 3'd0) ? 16'(1 << r[11:8]) : 16'h0, r[14:12] == 3'd0);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule